// File: doc/BRIEF.md
# Latched Status and Interrupt Register Bank

This block is a small bank of 8-bit status registers that a host processor polls over a simple parallel register bus. Each status bit is driven by one raw condition line from elsewhere on the chip. A bit is either alarm-type, where the line is a level that may stay active for a long time, or event-type, where a rising edge on the line marks a single occurrence. All raw lines are asynchronous to the bus clock and pass through a two-flop synchroniser before they are used.

The host never reads live status directly. It first writes a byte that selects which bits of a status register to sample into a held read-back byte, then reads that byte, then writes back the value it read ANDed with its mask. That second write clears exactly the selected bits that were set, without disturbing the others. Each status register has a companion interrupt mask register. Any unmasked pending source pulls a single active-low interrupt line. An alarm bit raises its source on every change of the alarm, and an event bit raises its source on each occurrence. Reading the bit releases the source.

Register map: status register k sits at address k, and its interrupt mask register sits at address N_REG + k. The parameter ALARM_MAP marks alarm-type bits with a one, one byte per status register, with register 0 in the low byte.

Top module: `stat_irq_bank`

## Requirements
- R1: A status bit is set when its alarm line is active or its event line rises. It stays at one until cleared by R4. A raw line change becomes visible in status on the third rising clock edge after it.
- R2: After a clearing write, an alarm-type status bit stays at one while its alarm line is still active. A low alarm line never sets a bit by itself.
- R3: A write to a status address is a mask. For each bit written as one, the read-back byte takes the current latched status. For each bit written as zero, the read-back byte keeps its old value. A read of a status address returns the read-back byte.
- R4: A write to a status address clears a status bit only if that bit is written as one and was selected by the previous write to that register followed by a read of it. All other bits keep their status.
- R5: When an event occurs in the same cycle as a write that would clear its bit, the bit stays set.
- R6: The interrupt mask register at address N_REG + k is written and read back directly. A one enables that bit as an interrupt source. It resets to zero.
- R7: For an alarm-type bit, both the rising and the falling change of the alarm line make its interrupt source pending. A read of the status register releases the source for the bits selected by the last write, even if the alarm is still active.
- R8: For an event-type bit, an occurrence makes its interrupt source pending. A read that covers the bit releases it. The falling edge of an event line does nothing.
- R9: irq_n is low exactly when some pending source has its mask bit at one. After reset, status, read-back, pending and mask state are all zero and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_cond | input | 8*N_REG | Asynchronous alarm levels and event lines, byte k feeds status register k |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The critical collision is an event occurrence landing on the same clock edge as the write-back that clears its bit. The bench provokes it by raising an event line and then timing the clearing write to reach the edge where the synchronised rising edge is seen. The bit must survive, and a following mask-read pair must show it still set with its interrupt pending. A second overlap, an alarm that stays active across a clearing write, is covered both in directed steps and by random toggling. The bench's own model predicts every read-back byte and the level of irq_n.

// File: rtl/sib_pkg.sv
package sib_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // synchronised view of one register's raw lines
    typedef struct packed {
        byte_t lvl;   // current synchronised level
        byte_t chg;   // level changed this cycle
        byte_t rise;  // level rose this cycle
    } cond_t;

    // status set vector: alarms follow level, events follow rising edge
    function automatic byte_t sib_set(cond_t c, byte_t amap);
        return (amap & c.lvl) | (~amap & c.rise);
    endfunction

    // interrupt source vector: alarms on any change, events on rising edge
    function automatic byte_t sib_irq(cond_t c, byte_t amap);
        return (amap & c.chg) | (~amap & c.rise);
    endfunction
endpackage

// File: rtl/sib_cond_sync.sv
module sib_cond_sync
    import sib_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t raw,
    output cond_t cond
);
    byte_t meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cond.lvl  = sync_q;
    assign cond.chg  = sync_q ^ prev_q;
    assign cond.rise = sync_q & ~prev_q;
endmodule

// File: rtl/sib_slice.sv
module sib_slice
    import sib_pkg::*;
#(
    parameter byte_t ALARM_MASK = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  cond_t cond,
    input  logic  st_wr,
    input  logic  st_rd,
    input  logic  im_wr,
    input  byte_t wdata,
    output byte_t rback,
    output byte_t imask,
    output logic  irq_any
);
    byte_t status_q, pend_q, rb_q, armed_q, seen_q, im_q;
    byte_t set_v, ipset_v, clr_v, rel_v;

    always_comb begin
        set_v   = sib_set(cond, ALARM_MASK);
        ipset_v = sib_irq(cond, ALARM_MASK);
        clr_v   = st_wr ? (wdata & seen_q) : '0;
        rel_v   = st_rd ? armed_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            pend_q   <= '0;
            rb_q     <= '0;
            armed_q  <= '0;
            seen_q   <= '0;
            im_q     <= '0;
        end else begin
            status_q <= set_v | (status_q & ~clr_v);
            pend_q   <= ipset_v | (pend_q & ~rel_v);
            if (st_wr) begin
                rb_q    <= (wdata & status_q) | (~wdata & rb_q);
                armed_q <= wdata;
                seen_q  <= '0;
            end else if (st_rd) begin
                seen_q  <= armed_q;
            end
            if (im_wr) im_q <= wdata;
        end
    end

    assign rback   = rb_q;
    assign imask   = im_q;
    assign irq_any = |(pend_q & im_q);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(set_v)) == $past(set_v))); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~$past(clr_v)) & ~status_q) == '0)); // R1
    AST_RB_MASK: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> (((rb_q ^ $past(rb_q)) & ~$past(wdata)) == '0)); // R3
    AST_IM_LOAD: assert property (@(posedge clk) disable iff (rst)
        im_wr |=> (im_q == $past(wdata))); // R6
    AST_IRQ_REL: assert property (@(posedge clk) disable iff (rst)
        st_rd |=> ((pend_q & $past(armed_q) & ~$past(ipset_v)) == '0)); // R7
endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank
    import sib_pkg::*;
#(
    parameter int N_REG = 2,
    parameter logic [N_REG*BYTE_W-1:0] ALARM_MAP = 16'h000F,
    localparam int ADDR_W = $clog2(2 * N_REG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REG*BYTE_W-1:0] raw_cond,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [BYTE_W-1:0]       reg_wdata,
    output logic [BYTE_W-1:0]       reg_rdata,
    output logic                    irq_n
);
    byte_t            rb_arr [N_REG];
    byte_t            im_arr [N_REG];
    logic [N_REG-1:0] irq_vec;

    for (genvar k = 0; k < N_REG; k++) begin : g_reg
        cond_t cond_k;
        logic  st_sel, im_sel;

        assign st_sel = (reg_addr == ADDR_W'(k));
        assign im_sel = (reg_addr == ADDR_W'(N_REG + k));

        sib_cond_sync u_sync (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_cond[k*BYTE_W +: BYTE_W]),
            .cond (cond_k)
        );

        sib_slice #(
            .ALARM_MASK (ALARM_MAP[k*BYTE_W +: BYTE_W])
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .cond    (cond_k),
            .st_wr   (reg_wr & st_sel),
            .st_rd   (reg_rd & st_sel),
            .im_wr   (reg_wr & im_sel),
            .wdata   (reg_wdata),
            .rback   (rb_arr[k]),
            .imask   (im_arr[k]),
            .irq_any (irq_vec[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_REG; k++) begin
            if (reg_addr == ADDR_W'(k))         reg_rdata = rb_arr[k];
            if (reg_addr == ADDR_W'(N_REG + k)) reg_rdata = im_arr[k];
        end
    end

    assign irq_n = ~|irq_vec;

    AST_IRQ_RESET: assert property (@(posedge clk)
        rst |=> irq_n); // R9
endmodule

// File: tb/stat_irq_bank_bench.sv
module stat_irq_bank_bench;
    localparam int          NR   = 2;
    localparam logic [15:0] AMAP = 16'h000F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] raw_cond = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] st_m [NR];
    logic [7:0] ip_m [NR];
    logic [7:0] rb_m [NR];
    logic [7:0] arm_m[NR];
    logic [7:0] seen_m[NR];
    logic [7:0] im_m [NR];

    stat_irq_bank #(.N_REG(NR), .ALARM_MAP(AMAP)) u_stat_irq_bank (
        .clk(clk), .rst(rst), .raw_cond(raw_cond), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] amap_of(int r);
        return AMAP[r*8 +: 8];
    endfunction

    function automatic logic exp_irq_n();
        logic any = 1'b0;
        for (int r = 0; r < NR; r++) any |= |(ip_m[r] & im_m[r]);
        return ~any;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_irq(input string tag);
        check({7'd0, irq_n}, {7'd0, exp_irq_n()}, tag);
    endtask

    // model of a status write, inputs settled
    task automatic model_wr_status(input int r, input logic [7:0] d);
        logic [7:0] pre = st_m[r];
        logic [7:0] clr = d & seen_m[r];
        st_m[r]   = (pre & ~clr) | (amap_of(r) & raw_cond[r*8 +: 8]);
        rb_m[r]   = (d & pre) | (~d & rb_m[r]);
        arm_m[r]  = d;
        seen_m[r] = '0;
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 2'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < NR) model_wr_status(a, d);
        else        im_m[a-NR] = d;
    endtask

    task automatic bus_rd(input int a, input string tag);
        @(negedge clk);
        reg_addr = 2'(a); reg_rd = 1'b1;
        #2;
        check(reg_rdata, (a < NR) ? rb_m[a] : im_m[a-NR], tag);
        @(negedge clk);
        reg_rd = 1'b0;
        if (a < NR) begin
            seen_m[a] = arm_m[a];
            ip_m[a]   = ip_m[a] & ~arm_m[a];
        end
    endtask

    task automatic set_line(input int r, input int b, input logic v);
        logic old;
        @(negedge clk);
        old = raw_cond[r*8+b];
        raw_cond[r*8+b] = v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        if (amap_of(r)[b]) begin
            if (old != v) ip_m[r][b] = 1'b1;
            if (v) st_m[r][b] = 1'b1;
        end else if (!old && v) begin
            st_m[r][b] = 1'b1;
            ip_m[r][b] = 1'b1;
        end
    endtask

    // full poll: mask, read, write back
    task automatic poll(input int r, input logic [7:0] m, input string tag);
        logic [7:0] got;
        bus_wr(r, m);
        got = rb_m[r];
        bus_rd(r, tag);
        bus_wr(r, got & m);
    endtask

    initial begin
        for (int r = 0; r < NR; r++) begin
            st_m[r] = '0; ip_m[r] = '0; rb_m[r] = '0;
            arm_m[r] = '0; seen_m[r] = '0; im_m[r] = '0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9 reset state
        for (int a = 0; a < 2*NR; a++) bus_rd(a, "R9 reset read");
        check_irq("R9 reset irq_n");

        // R6 mask write/read back
        bus_wr(2, 8'h5A); bus_rd(2, "R6 mask readback");
        bus_wr(2, 8'hFF); bus_wr(3, 8'hFF); bus_rd(3, "R6 mask readback");

        // R1 event latch, R8 irq on occurrence
        set_line(1, 2, 1'b1); set_line(1, 2, 1'b0);
        check_irq("R8 event irq");
        bus_wr(1, 8'h04); bus_rd(1, "R1 event latched");
        check_irq("R8 event irq released");
        bus_wr(1, 8'h04);
        bus_wr(1, 8'h04); bus_rd(1, "R4 event cleared");

        // R3 unselected bits hold read-back
        set_line(1, 5, 1'b1); set_line(1, 5, 1'b0);
        bus_wr(1, 8'h00); bus_rd(1, "R3 zero mask holds");

        // R2/R7 alarm persists across clear, source released while active
        set_line(0, 1, 1'b1);
        check_irq("R7 alarm rise irq");
        poll(0, 8'h02, "R2 alarm set");
        check_irq("R7 released while active");
        bus_wr(0, 8'h02); bus_rd(0, "R2 alarm still set");
        set_line(0, 1, 1'b0);
        check_irq("R7 alarm fall irq");
        poll(0, 8'h02, "R7 alarm fall read");
        bus_wr(0, 8'h02); bus_rd(0, "R4 alarm cleared");

        // R5 event on the same edge as the clearing write
        set_line(1, 0, 1'b1); set_line(1, 0, 1'b0);
        bus_wr(1, 8'h01); bus_rd(1, "R5 setup");
        @(negedge clk);
        raw_cond[8] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        model_wr_status(1, 8'h01);
        st_m[1][0] = 1'b1; ip_m[1][0] = 1'b1;
        repeat (3) @(negedge clk);
        check_irq("R5 collision irq");
        bus_wr(1, 8'h01); bus_rd(1, "R5 set wins over clear");
        set_line(1, 0, 1'b0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op = int'($urandom_range(0, 4));
            int r  = int'($urandom_range(0, NR-1));
            int b  = int'($urandom_range(0, 7));
            logic [7:0] m = 8'($urandom);
            case (op)
                0: if (amap_of(r)[b]) set_line(r, b, ~raw_cond[r*8+b]);
                   else begin set_line(r, b, 1'b1); set_line(r, b, 1'b0); end
                1: bus_wr(r, m);
                2: bus_rd(r, "R3 random read");
                3: poll(r, m, "R4 random poll");
                default: begin bus_wr(NR + r, m); bus_rd(NR + r, "R6 random mask"); end
            endcase
            check_irq("R9 random irq_n");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule